// File: doc/BRIEF.md
# Streaming Block Corner-Turn Transposer

This block reorders a continuous stream of words. Each group of N×N consecutive words is treated as a square block written row by row: row 0 first, element 0 of each row first. The block sends the same words out column by column. Element 0 of every row leaves before element 1 of any row, and so on. One word enters and one word leaves on every clock. Consecutive blocks follow each other with no idle cycles, and the delay from input to output is the same for every word.

The datapath has five stages:
- A row gatherer collects each row into a vector.
- A bank of skew lanes delays lane i by i row periods.
- A barrel rotator turns the vector by an amount taken from the row position inside the block.
- A bank of de-skew lanes delays lane k by N−1−k row periods.
- A column emitter shifts the result out one word per clock.

This needs 2(N−1) lanes that actually store data, instead of a double-buffered N×N register array. A `blk_start` pulse marks the word that is element (0,0) of a block and realigns the position counters. N is a power of two of at least 4.

Top module: `ct_transposer`

## Requirements
- R1: During and directly after synchronous reset, `dout_valid` is 0 and `dout` is 0.
- R2: Words presented before the first `blk_start` are ignored: `dout_valid` stays 0 and `dout` stays 0 until the first valid output.
- R3: For a block starting at input word b, output word b + N·N + c·N + r carries input word b + r·N + c (row r, column c), i.e. column-major order.
- R4: `dout_valid` rises exactly N·N cycles after the cycle in which the first `blk_start` is presented. Every output word leaves exactly N·N cycles after its slot in the input stream.
- R5: Once high, `dout_valid` stays high and back-to-back blocks emerge with no gap cycles.
- R6: `dout` is 0 in every cycle in which `dout_valid` is 0.
- R7: A `blk_start` presented on a word that is already element (0,0) of a block does not change the output.
- R8: A `blk_start` in the middle of a block makes that word element (0,0) of a new block. Every complete block from there on is transposed correctly, with the same N·N latency. Output of a block whose emergence is interrupted by such a realignment is undefined.
- R9: With N = 4 the same ordering holds with a latency of 16 cycles. For example, a group-interleaved stream C0 M0 Y0 K0 C1 M1 Y1 K1 … leaves as C0 C1 C2 C3 M0 … K3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| blk_start | input | 1 | Marks the current input word as element (0,0) of a block |
| din | input | W | Input word, one per clock once started |
| dout | output | W | Output word in column-major order, 0 when not valid |
| dout_valid | output | 1 | High from N·N cycles after the first `blk_start` onward |

## Verification
A wrong rotate phase or a lane of the wrong length does not stall the block. It shows as words taken from the wrong row or column, starting in the first column of the first block, N·N cycles after the start. A position counter that drifts away from the row structure corrupts every later block. The output is therefore compared word by word against a transpose of the logged input, in every cycle. A fault in the fill logic appears as `dout_valid` rising one or more cycles off the N·N mark, or dropping later. The valid flag is therefore checked in every cycle as well.

// File: rtl/ct_pkg.sv
package ct_pkg;

    // Order of lane lengths inside a delay bank.
    typedef enum logic {
        SKEW_RISING  = 1'b0,   // lane i holds i row periods
        SKEW_FALLING = 1'b1    // lane i holds N-1-i row periods
    } lane_order_e;

    // Number of row periods a given lane delays by.
    function automatic int lane_depth(lane_order_e ord, int idx, int lanes);
        return (ord == SKEW_RISING) ? idx : (lanes - 1 - idx);
    endfunction

    // Number of storage stages a whole bank uses.
    function automatic int bank_words(int lanes);
        return (lanes * (lanes - 1)) / 2;
    endfunction

endpackage

// File: rtl/ct_sequencer.sv
module ct_sequencer #(
    parameter int N  = 16,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          blk_start,
    output logic          running,
    output logic          step,
    output logic [LW-1:0] col,
    output logic [LW-1:0] phase,
    output logic          out_valid
);
    // Position of the current word inside its block.
    typedef struct packed {
        logic [LW-1:0] row;
        logic [LW-1:0] col;
    } pos_t;

    localparam logic [LW-1:0]   LAST = LW'(N - 1);
    localparam logic [2*LW-1:0] ONE  = (2*LW)'(1);

    pos_t          pos_q, pos_cur;
    logic          run_q;
    logic          vld_q;
    logic [LW-1:0] fill_q;

    // A start pulse forces the current word to element (0,0).
    always_comb begin
        pos_cur = blk_start ? '0 : pos_q;
    end

    assign running   = blk_start | run_q;
    assign step      = running && (pos_cur.col == LAST);
    assign col       = pos_cur.col;
    assign phase     = pos_cur.row;
    assign out_valid = vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            run_q <= 1'b0;
        end else if (running) begin
            pos_q <= pos_t'(pos_cur + ONE);
            run_q <= 1'b1;
        end
    end

    // The first column of the first block is complete on step N-1.
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
            vld_q  <= 1'b0;
        end else if (step && !vld_q) begin
            if (fill_q == LAST) vld_q  <= 1'b1;
            else                fill_q <= fill_q + LW'(1);
        end
    end

    assert_col_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        step |=> (pos_q.col == '0));

    assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        !$fell(vld_q));

    assert_valid_on_step_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(vld_q) |-> $past(step));

    assert_no_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> run_q);

endmodule

// File: rtl/ct_row_gather.sv
module ct_row_gather #(
    parameter int N  = 16,
    parameter int W  = 16,
    localparam int LW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  logic [LW-1:0]       col,
    input  logic [W-1:0]        din,
    output logic [N-1:0][W-1:0] row_vec
);
    // The last word of a row bypasses storage so the full row is
    // available in the same cycle that the word arrives.
    assign row_vec[N-1] = din;

    for (genvar j = 0; j < N - 1; j++) begin : g_slot
        localparam logic [LW-1:0] SLOT = LW'(j);
        logic [W-1:0] held_q;

        always_ff @(posedge clk) begin
            if (rst)                        held_q <= '0;
            else if (take && col == SLOT)   held_q <= din;
        end

        assign row_vec[j] = held_q;

        assert_gather_slot_R3: assert property (@(posedge clk) disable iff (rst)
            (take && col == SLOT) |=> (held_q == $past(din)));
    end

endmodule

// File: rtl/ct_delay_bank.sv
module ct_delay_bank #(
    parameter int                  N     = 16,
    parameter int                  W     = 16,
    parameter ct_pkg::lane_order_e ORDER = ct_pkg::SKEW_RISING
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift,
    input  logic [N-1:0][W-1:0] vin,
    output logic [N-1:0][W-1:0] vout
);
    // Every lane moves only on a row step, so its depth counts rows.
    for (genvar i = 0; i < N; i++) begin : g_lane
        localparam int D = ct_pkg::lane_depth(ORDER, i, N);

        if (D == 0) begin : g_pass
            assign vout[i] = vin[i];
        end else begin : g_store
            logic [W-1:0] sr_q [D];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int m = 0; m < D; m++) sr_q[m] <= '0;
                end else if (shift) begin
                    sr_q[0] <= vin[i];
                    for (int m = 1; m < D; m++) sr_q[m] <= sr_q[m-1];
                end
            end

            // Oldest entry is read before the shift that drops it.
            assign vout[i] = sr_q[D-1];

            assert_lane_hold_R4: assert property (@(posedge clk) disable iff (rst)
                !shift |=> $stable(sr_q[D-1]));
        end
    end

endmodule

// File: rtl/ct_rotator.sv
module ct_rotator #(
    parameter int N  = 16,
    parameter int W  = 16,
    localparam int LW = $clog2(N)
) (
    input  logic [LW-1:0]       phase,
    input  logic [N-1:0][W-1:0] vin,
    output logic [N-1:0][W-1:0] vout
);
    // Output lane k takes input lane (phase - k) mod N. Output lane k
    // then always carries block row k, whichever column it holds.
    for (genvar k = 0; k < N; k++) begin : g_out
        localparam logic [LW-1:0] KI = LW'(k);
        logic [LW-1:0] sel;

        assign sel     = phase - KI;
        assign vout[k] = vin[sel];
    end

    always_comb begin
        if (phase == '0) begin
            assert_rot_zero_R3: assert (vout[0] == vin[0]);
        end
    end

endmodule

// File: rtl/ct_col_emit.sv
module ct_col_emit #(
    parameter int N = 16,
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                vld,
    input  logic [N-1:0][W-1:0] vin,
    output logic [W-1:0]        dout
);
    logic [N-1:0][W-1:0] obuf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            obuf_q <= '0;
        end else if (load) begin
            obuf_q <= vin;
        end else begin
            for (int i = 0; i < N - 1; i++) obuf_q[i] <= obuf_q[i+1];
            obuf_q[N-1] <= '0;
        end
    end

    // Fill garbage is kept off the port until the first real column.
    assign dout = vld ? obuf_q[0] : '0;

    assert_emit_first_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (obuf_q[0] == $past(vin[0])));

    assert_emit_shift_R5: assert property (@(posedge clk) disable iff (rst)
        !load |=> (obuf_q[0] == $past(obuf_q[1])));

endmodule

// File: rtl/ct_transposer.sv
module ct_transposer #(
    parameter int N = 16,
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         blk_start,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         dout_valid
);
    localparam int LW = $clog2(N);

    logic                running, step, vld;
    logic [LW-1:0]       col, phase;
    logic [N-1:0][W-1:0] row_vec, skewed, turned, aligned;

    ct_sequencer #(.N(N)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .blk_start (blk_start),
        .running   (running),
        .step      (step),
        .col       (col),
        .phase     (phase),
        .out_valid (vld)
    );

    ct_row_gather #(.N(N), .W(W)) u_gather (
        .clk     (clk),
        .rst     (rst),
        .take    (running),
        .col     (col),
        .din     (din),
        .row_vec (row_vec)
    );

    ct_delay_bank #(.N(N), .W(W), .ORDER(ct_pkg::SKEW_RISING)) u_skew (
        .clk   (clk),
        .rst   (rst),
        .shift (step),
        .vin   (row_vec),
        .vout  (skewed)
    );

    ct_rotator #(.N(N), .W(W)) u_rot (
        .phase (phase),
        .vin   (skewed),
        .vout  (turned)
    );

    ct_delay_bank #(.N(N), .W(W), .ORDER(ct_pkg::SKEW_FALLING)) u_deskew (
        .clk   (clk),
        .rst   (rst),
        .shift (step),
        .vin   (turned),
        .vout  (aligned)
    );

    ct_col_emit #(.N(N), .W(W)) u_emit (
        .clk  (clk),
        .rst  (rst),
        .load (step),
        .vld  (vld),
        .vin  (aligned),
        .dout (dout)
    );

    assign dout_valid = vld;

    // The word after a start is column 1, never the end of a row (N >= 4).
    assert_start_realign_R8: assert property (@(posedge clk) disable iff (rst)
        blk_start |=> !step);

endmodule

// File: tb/test_ct_transposer.sv
module test_ct_transposer;

    localparam int NTOT = 1340;
    localparam int S0   = 8;               // first start
    localparam int RP   = S0 + 768 + 37;   // misaligned restart point

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] din = '0;
    logic        st_a = 1'b0, st_b = 1'b0;
    logic [15:0] dout_a, dout_b;
    logic        vld_a, vld_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] inlog [NTOT];
    int          pos_a [NTOT];
    int          pos_b [NTOT];
    bit          mis_a [NTOT];
    bit          mis_b [NTOT];

    always #5 clk = ~clk;   // 100 MHz

    ct_transposer #(.N(16), .W(16)) i_ct_transposer (
        .clk(clk), .rst(rst), .blk_start(st_a), .din(din),
        .dout(dout_a), .dout_valid(vld_a));

    ct_transposer #(.N(4), .W(16)) i_ct_transposer_n4 (
        .clk(clk), .rst(rst), .blk_start(st_b), .din(din),
        .dout(dout_b), .dout_valid(vld_b));

    function automatic int getpos(int which, int i);
        return which != 0 ? pos_b[i] : pos_a[i];
    endfunction

    function automatic bit getmis(int which, int i);
        return which != 0 ? mis_b[i] : mis_a[i];
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Compare one instance's outputs in cycle t against the model.
    task automatic check_port(input int which, input int t,
                              input logic v, input logic [15:0] d);
        int nn = (which != 0) ? 16 : 256;
        int nl = (which != 0) ? 4 : 16;
        bit expv = (t >= S0 + nn);
        string tag;
        string what;
        what = $sformatf("inst N=%0d cycle %0d", nl, t);
        if (t < S0)           tag = "R2";
        else if (t <= S0 + nn) tag = "R4";
        else                  tag = "R5";
        check(tag, {what, " valid"}, {15'd0, v}, {15'd0, expv});
        if (!expv) begin
            check((t < S0) ? "R2" : "R6", {what, " idle data"}, d, 16'h0000);
        end else begin
            int m = t - nn;
            int p = getpos(which, m);
            if (p >= 0) begin
                int b = m - p;
                int e = b + nn - 1;
                bit ok = (e < t) && (getpos(which, e) == nn - 1);
                for (int i = b + nn; ok && i < t; i++)
                    if (getmis(which, i)) ok = 0;
                if (ok) begin
                    int src = b + (p % nl) * nl + p / nl;
                    if (which != 0)  tag = "R9";
                    else if (b >= RP) tag = "R8";
                    else if (b == S0) tag = "R3";
                    else             tag = "R7";
                    check(tag, {what, " data"}, d, inlog[src]);
                end
            end
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state under reset
        check("R1", "reset valid N=16", {15'd0, vld_a}, 16'h0000);
        check("R1", "reset data N=16",  dout_a, 16'h0000);
        check("R1", "reset valid N=4",  {15'd0, vld_b}, 16'h0000);
        check("R1", "reset data N=4",   dout_b, 16'h0000);
        rst = 1'b0;
        for (int n = 0; n < NTOT; n++) begin
            logic [15:0] w;
            bit sa, sb;
            int pa, pb;
            check_port(0, n, vld_a, dout_a);
            check_port(1, n, vld_b, dout_b);
            // stimulus
            if (n >= S0 && n < S0 + 16)
                w = 16'(((((n - S0) % 4) + 1) << 12) | ((n - S0) / 4)); // C/M/Y/K groups
            else if (n >= S0 + 16 && n < S0 + 32)
                w = (n % 2 != 0) ? 16'hFFFF : 16'h0000;
            else
                w = 16'($urandom);
            sa = (n == S0) || (n == S0 + 256) || (n == S0 + 512) ||
                 (n == RP) || (n == RP + 256);
            sb = (n == S0) || (n == RP) ||
                 (n > S0 && n < RP && (n - S0) % 16 == 0 && ((n - S0) / 16) % 3 == 0) ||
                 (n > RP && (n - RP) % 16 == 0 && ($urandom % 2) == 1);
            din  = w;
            st_a = sa;
            st_b = sb;
            inlog[n] = w;
            pa = (n == 0) ? -1 : pos_a[n-1];
            pb = (n == 0) ? -1 : pos_b[n-1];
            mis_a[n] = sa && (pa >= 0) && (((pa + 1) % 256) != 0);
            mis_b[n] = sb && (pb >= 0) && (((pb + 1) % 16) != 0);
            pos_a[n] = sa ? 0 : (pa < 0 ? -1 : (pa + 1) % 256);
            pos_b[n] = sb ? 0 : (pb < 0 ? -1 : (pb + 1) % 16);
            @(negedge clk);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule